// File: doc/BRIEF.md
# AHB-Lite Burst Address Generator

This block sits on the requester side of an AHB-Lite bus and turns one burst descriptor into the address-phase signals for every beat of that burst. A descriptor carries a start address, a burst code, a transfer size and a direction. The block drives the address, the transfer type, the burst code, the size and the write flag. It steps the address from beat to beat, wrapping or incrementing as the burst code asks. The data phase is handled elsewhere.

Descriptors arrive on a valid/ready handshake. The generator raises `desc_ready` only when it is idle and the completer has `hready` high. A descriptor is taken on a clock edge where both `desc_valid` and `desc_ready` are high. While `desc_ready` is low the source must hold `desc_valid` and the descriptor fields stable. A descriptor the bus may not carry is refused: `desc_err` pulses and the bus shows no activity.

Two plain control inputs shape a burst while it runs. `busy_req` asks for BUSY cycles between beats. `incr_more` keeps an undefined-length burst going. Whenever `hready` is low, every address-phase output holds its value.

Top module: `ahb_burst_agen`

## Requirements
- R1: After reset `htrans` is IDLE (2'b00), `desc_ready` is high and `desc_err` is low.
- R2: `desc_ready` is high only when `htrans` is IDLE and `hready` is high. The cycle after a descriptor is accepted shows its first beat as NONSEQ (2'b10) at the start address. `hburst`, `hsize` and `hwrite` equal the descriptor fields for the whole burst.
- R3: In an incrementing burst each later beat is SEQ (2'b11) at the previous address plus 2^size bytes. The burst codes are: 3'b000 single, 3'b001 undefined-length incrementing, 3'b011/3'b101/3'b111 incrementing 4/8/16 beats. Sizes 3'b000, 3'b001 and 3'b010 mean 1, 2 and 4 bytes.
- R4: The wrapping codes 3'b010, 3'b100 and 3'b110 give 4, 8 and 16 beats. The address wraps inside an aligned block of beats times 2^size bytes.
- R5: When a non-final beat is accepted while `busy_req` is high, the next cycle shows BUSY (2'b01) at the next beat's address. BUSY holds while `busy_req` stays high. The following beat is SEQ at that same address. `busy_req` has no effect when the final beat is accepted; IDLE follows.
- R6: While `hready` is low, `haddr`, `htrans`, `hburst`, `hsize` and `hwrite` keep their values.
- R7: An undefined-length burst continues while `incr_more` is high. It ends with IDLE on the cycle after a beat or BUSY is accepted with `incr_more` low.
- R8: When an undefined-length burst steps onto a 1KB boundary, that beat is issued as NONSEQ rather than SEQ.
- R9: A descriptor is rejected in three cases: its start address is not aligned to its size; its size exceeds 3'b010; or it is a fixed-length incrementing burst whose last byte lies in a different 1KB page. On rejection `desc_err` is high for exactly the cycle after acceptance and `htrans` stays IDLE.
- R10: After the final beat of a fixed-length burst is accepted, `htrans` returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Generator can take a descriptor |
| desc_addr | input | ADDR_W | Burst start address |
| desc_burst | input | 3 | Burst code |
| desc_size | input | 3 | Transfer size code |
| desc_write | input | 1 | 1 for write, 0 for read |
| desc_err | output | 1 | One-cycle pulse: descriptor refused |
| busy_req | input | 1 | Insert BUSY before the next beat |
| incr_more | input | 1 | Keep an undefined-length burst going |
| hready | input | 1 | Completer ready; low stretches the address phase |
| haddr | output | ADDR_W | Address of the current beat |
| htrans | output | 2 | Transfer type |
| hburst | output | 3 | Burst code |
| hsize | output | 3 | Transfer size |
| hwrite | output | 1 | Direction |

## Verification
Every result of this block is due exactly one clock edge after the input that causes it:
- the first NONSEQ beat, or the `desc_err` pulse, after a descriptor is accepted;
- each following beat, BUSY cycle or IDLE after the current beat is accepted.

The bench therefore changes inputs at a falling edge and checks outputs at the next falling edge, so one rising edge always lies between stimulus and check. When `hready` is held low, the checks at each falling edge expect no change at all. The expected address of each beat comes from modulo arithmetic over the wrap block, worked out in the bench.

// File: rtl/ahb_burst_pkg.sv
package ahb_burst_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  localparam logic [2:0] BT_SINGLE = 3'b000;
  localparam logic [2:0] BT_INCR   = 3'b001;

  // log2 of the beat count of a fixed-length code; 0 for single and undefined
  function automatic logic [2:0] beats_log2(input logic [2:0] code);
    case (code[2:1])
      2'b01:   beats_log2 = 3'd2;
      2'b10:   beats_log2 = 3'd3;
      2'b11:   beats_log2 = 3'd4;
      default: beats_log2 = 3'd0;
    endcase
  endfunction

  function automatic logic is_wrap(input logic [2:0] code);
    is_wrap = (code[0] == 1'b0) && (code != BT_SINGLE);
  endfunction

  function automatic logic is_fixed_incr(input logic [2:0] code);
    is_fixed_incr = code[0] && (code != BT_INCR);
  endfunction

endpackage

// File: rtl/burst_desc_check.sv
module burst_desc_check
  import ahb_burst_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_SIZE  = 2,
  parameter int PAGE_LOG2 = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        burst,
  input  logic [2:0]        size,
  output logic              ok,
  output logic [3:0]        beats_m1
);
  localparam int PAGE_HI = ADDR_W - PAGE_LOG2;

  logic [ADDR_W-1:0] lane_mask;
  logic [ADDR_W-1:0] last_addr;
  logic              size_ok, aligned, crosses;

  always_comb begin
    beats_m1  = 4'((5'd1 << beats_log2(burst)) - 5'd1);
    size_ok   = (int'(size) <= MAX_SIZE);
    lane_mask = (ADDR_W'(1) << size) - ADDR_W'(1);
    aligned   = ((addr & lane_mask) == '0);
    last_addr = addr + (ADDR_W'(beats_m1) << size);
    crosses   = is_fixed_incr(burst) &&
                (addr[ADDR_W-1 -: PAGE_HI] != last_addr[ADDR_W-1 -: PAGE_HI]);
    ok        = size_ok && aligned && !crosses;
  end

endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
  import ahb_burst_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_LOG2 = 10
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [2:0]        burst,
  input  logic [2:0]        size,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              page_edge
);
  logic [ADDR_W-1:0] step, sum, wrap_mask;

  always_comb begin
    step      = ADDR_W'(1) << size;
    sum       = cur_addr + step;
    wrap_mask = (ADDR_W'(1) << (size + beats_log2(burst))) - ADDR_W'(1);
    if (is_wrap(burst))
      nxt_addr = (cur_addr & ~wrap_mask) | (sum & wrap_mask);
    else
      nxt_addr = sum;
    page_edge = (nxt_addr[PAGE_LOG2-1:0] == '0);
  end

endmodule

// File: rtl/ahb_burst_agen.sv
module ahb_burst_agen
  import ahb_burst_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_SIZE  = 2,
  parameter int PAGE_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [2:0]        desc_burst,
  input  logic [2:0]        desc_size,
  input  logic              desc_write,
  output logic              desc_err,
  input  logic              busy_req,
  input  logic              incr_more,
  input  logic              hready,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic [2:0]        hburst,
  output logic [2:0]        hsize,
  output logic              hwrite
);
  htrans_e           trans_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        burst_q, size_q;
  logic              write_q, undef_q, restart_q, err_q;
  logic [3:0]        left_q;

  logic              chk_ok;
  logic [3:0]        chk_beats_m1;
  logic [ADDR_W-1:0] nxt_addr;
  logic              page_edge;
  logic              accept, beat_last;

  burst_desc_check #(.ADDR_W(ADDR_W), .MAX_SIZE(MAX_SIZE), .PAGE_LOG2(PAGE_LOG2)) check_i (
    .addr(desc_addr), .burst(desc_burst), .size(desc_size),
    .ok(chk_ok), .beats_m1(chk_beats_m1)
  );

  burst_next_addr #(.ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2)) step_i (
    .cur_addr(addr_q), .burst(burst_q), .size(size_q),
    .nxt_addr(nxt_addr), .page_edge(page_edge)
  );

  assign desc_ready = (trans_q == TR_IDLE) && hready;
  assign accept     = desc_valid && desc_ready;
  assign beat_last  = undef_q ? !incr_more : (left_q == 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trans_q   <= TR_IDLE;
      addr_q    <= '0;
      burst_q   <= BT_SINGLE;
      size_q    <= '0;
      write_q   <= 1'b0;
      undef_q   <= 1'b0;
      restart_q <= 1'b0;
      err_q     <= 1'b0;
      left_q    <= '0;
    end else begin
      err_q <= accept && !chk_ok;
      if (hready) begin
        case (trans_q)
          TR_IDLE: begin
            if (desc_valid && chk_ok) begin
              trans_q   <= TR_NONSEQ;
              addr_q    <= desc_addr;
              burst_q   <= desc_burst;
              size_q    <= desc_size;
              write_q   <= desc_write;
              undef_q   <= (desc_burst == BT_INCR);
              left_q    <= chk_beats_m1;
              restart_q <= 1'b0;
            end
          end
          TR_NONSEQ, TR_SEQ: begin
            if (beat_last) begin
              trans_q <= TR_IDLE;
            end else begin
              addr_q    <= nxt_addr;
              restart_q <= undef_q && page_edge;
              if (!undef_q) left_q <= left_q - 4'd1;
              if (busy_req)                 trans_q <= TR_BUSY;
              else if (undef_q && page_edge) trans_q <= TR_NONSEQ;
              else                          trans_q <= TR_SEQ;
            end
          end
          TR_BUSY: begin
            if (undef_q && !incr_more) trans_q <= TR_IDLE;
            else if (!busy_req)        trans_q <= restart_q ? TR_NONSEQ : TR_SEQ;
          end
          default: trans_q <= TR_IDLE;
        endcase
      end
    end
  end

  assign haddr    = addr_q;
  assign htrans   = trans_q;
  assign hburst   = burst_q;
  assign hsize    = size_q;
  assign hwrite   = write_q;
  assign desc_err = err_q;

endmodule

// File: rtl/ahb_burst_agen_chk.sv
module ahb_burst_agen_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_LOG2 = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              desc_ready,
  input logic              desc_err,
  input logic              hready,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0]        htrans,
  input logic [2:0]        hburst,
  input logic [2:0]        hsize,
  input logic              hwrite
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> htrans == 2'b00);

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> (htrans == 2'b00 && hready));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> ($stable(haddr) && $stable(htrans) && $stable(hburst) &&
                 $stable(hsize) && $stable(hwrite)));

  // R3
  incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && htrans[1] && hburst[0]) |=>
      (htrans != 2'b11 || haddr == $past(haddr) + (ADDR_W'(1) << $past(hsize))));

  // R5
  busy_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && htrans == 2'b01) |=> (htrans == 2'b00 || haddr == $past(haddr)));

  // R8
  page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && htrans != 2'b00) |=>
      (htrans != 2'b11 ||
       haddr[ADDR_W-1:PAGE_LOG2] == $past(haddr[ADDR_W-1:PAGE_LOG2])));

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |-> htrans == 2'b00);

  // R2
  size_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    htrans != 2'b00 |-> hsize <= 3'b010);
endmodule

bind ahb_burst_agen ahb_burst_agen_chk #(.ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2)) chk_i (
  .clk(clk), .rst_n(rst_n), .desc_ready(desc_ready), .desc_err(desc_err),
  .hready(hready), .haddr(haddr), .htrans(htrans), .hburst(hburst),
  .hsize(hsize), .hwrite(hwrite)
);

// File: tb/ahb_burst_agen_tb.sv
module ahb_burst_agen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  burst;
    logic [2:0]  size;
    logic        wr;
    logic        err;
    logic [3:0]  busy_at;   // beat index followed by one BUSY; 15 = none
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{32'h0000_0034, 3'b010, 3'd2, 1'b0, 1'b0, 4'd15},
    '{32'h0000_1000, 3'b000, 3'd2, 1'b1, 1'b0, 4'd15},
    '{32'h0000_0020, 3'b011, 3'd1, 1'b1, 1'b0, 4'd1},
    '{32'h0000_1006, 3'b100, 3'd1, 1'b0, 1'b0, 4'd15},
    '{32'h0000_03C0, 3'b111, 3'd2, 1'b1, 1'b0, 4'd15},
    '{32'h0000_0007, 3'b101, 3'd0, 1'b0, 1'b0, 4'd3},
    '{32'h0000_003A, 3'b110, 3'd0, 1'b1, 1'b0, 4'd15},
    '{32'h0000_0102, 3'b011, 3'd2, 1'b0, 1'b1, 4'd15},
    '{32'h0000_03F0, 3'b111, 3'd2, 1'b0, 1'b1, 4'd15},
    '{32'h0000_0010, 3'b000, 3'd3, 1'b0, 1'b1, 4'd15},
    '{32'h0000_03F8, 3'b101, 3'd2, 1'b1, 1'b1, 4'd15}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic desc_valid = 1'b0, desc_write = 1'b0;
  logic [ADDR_W-1:0] desc_addr = '0;
  logic [2:0] desc_burst = '0, desc_size = '0;
  logic busy_req = 1'b0, incr_more = 1'b0, hready = 1'b1;
  logic desc_ready, desc_err, hwrite;
  logic [ADDR_W-1:0] haddr;
  logic [1:0] htrans;
  logic [2:0] hburst, hsize;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ahb_burst_agen dut_i (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_addr(desc_addr), .desc_burst(desc_burst), .desc_size(desc_size),
    .desc_write(desc_write), .desc_err(desc_err), .busy_req(busy_req),
    .incr_more(incr_more), .hready(hready), .haddr(haddr), .htrans(htrans),
    .hburst(hburst), .hsize(hsize), .hwrite(hwrite)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int n_beats(input logic [2:0] b);
    case (b)
      3'b010, 3'b011: return 4;
      3'b100, 3'b101: return 8;
      3'b110, 3'b111: return 16;
      default:        return 1;
    endcase
  endfunction

  function automatic logic [31:0] exp_addr(input vec_t t, input int i);
    int unsigned bytes, span, base;
    bytes = 1 << t.size;
    if (t.burst != 3'b000 && t.burst[0] == 1'b0) begin
      span = n_beats(t.burst) * bytes;
      base = (t.addr / span) * span;
      return base + ((t.addr - base + i * bytes) % span);
    end
    return t.addr + i * bytes;
  endfunction

  task automatic offer(input logic [31:0] a, input logic [2:0] b, input logic [2:0] s, input logic w);
    desc_addr = a; desc_burst = b; desc_size = s; desc_write = w; desc_valid = 1'b1;
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(htrans == 2'b00, "R1 htrans", htrans, 0);
    chk(desc_ready == 1'b1, "R1 desc_ready", desc_ready, 1);
    chk(desc_err == 1'b0, "R1 desc_err", desc_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int n;
      t = VECS[v];
      n = n_beats(t.burst);
      offer(t.addr, t.burst, t.size, t.wr);
      if (t.err) begin
        // R9 rejection
        chk(desc_err == 1'b1, "R9 err pulse", desc_err, 1);
        chk(htrans == 2'b00, "R9 no activity", htrans, 0);
        @(negedge clk);
        chk(desc_err == 1'b0, "R9 pulse width", desc_err, 0);
        chk(htrans == 2'b00, "R9 still idle", htrans, 0);
      end else begin
        for (int i = 0; i < n; i++) begin
          // R2 first beat / R3 R4 address sequence
          chk(htrans == (i == 0 ? 2'b10 : 2'b11), "R2/R3 htrans", htrans, (i == 0) ? 2 : 3);
          chk(haddr == exp_addr(t, i), "R3/R4 haddr", haddr, exp_addr(t, i));
          chk(hburst == t.burst && hsize == t.size && hwrite == t.wr, "R2 control",
              {hburst, hsize, hwrite}, {t.burst, t.size, t.wr});
          chk(desc_ready == 1'b0, "R2 ready low in burst", desc_ready, 0);
          if (i == int'(t.busy_at) && i < n - 1) begin
            busy_req = 1'b1;
            @(negedge clk);
            // R5 BUSY shows next beat address
            chk(htrans == 2'b01, "R5 busy", htrans, 1);
            chk(haddr == exp_addr(t, i + 1), "R5 busy addr", haddr, exp_addr(t, i + 1));
            busy_req = 1'b0;
          end
          @(negedge clk);
        end
        // R10 back to IDLE
        chk(htrans == 2'b00, "R10 idle after burst", htrans, 0);
      end
    end

    // R6 hold under wait states, then R5 busy ignored at final beat
    offer(32'h100, 3'b011, 3'd2, 1'b1);
    chk(htrans == 2'b10 && haddr == 32'h100, "R6 first beat", haddr, 32'h100);
    hready = 1'b0;
    @(negedge clk);
    chk(htrans == 2'b10 && haddr == 32'h100, "R6 hold 1", haddr, 32'h100);
    @(negedge clk);
    chk(htrans == 2'b10 && haddr == 32'h100, "R6 hold 2", haddr, 32'h100);
    chk(desc_ready == 1'b0, "R2 ready low when hready low", desc_ready, 0);
    hready = 1'b1;
    @(negedge clk);
    chk(htrans == 2'b11 && haddr == 32'h104, "R6 resume", haddr, 32'h104);
    @(negedge clk);
    @(negedge clk);
    chk(htrans == 2'b11 && haddr == 32'h10C, "R3 last beat", haddr, 32'h10C);
    busy_req = 1'b1;
    @(negedge clk);
    chk(htrans == 2'b00, "R5 busy ignored at end", htrans, 0);
    busy_req = 1'b0;
    @(negedge clk);

    // R7 R8 undefined-length burst across 1KB
    incr_more = 1'b1;
    offer(32'h3F8, 3'b001, 3'd2, 1'b0);
    chk(htrans == 2'b10 && haddr == 32'h3F8, "R7 first", haddr, 32'h3F8);
    @(negedge clk);
    chk(htrans == 2'b11 && haddr == 32'h3FC, "R7 seq", haddr, 32'h3FC);
    @(negedge clk);
    chk(htrans == 2'b10, "R8 restart nonseq", htrans, 2);
    chk(haddr == 32'h400, "R8 page addr", haddr, 32'h400);
    @(negedge clk);
    chk(htrans == 2'b11 && haddr == 32'h404, "R7 seq after page", haddr, 32'h404);
    busy_req = 1'b1;
    @(negedge clk);
    chk(htrans == 2'b01 && haddr == 32'h408, "R5 busy in undefined", haddr, 32'h408);
    busy_req = 1'b0;
    incr_more = 1'b0;
    @(negedge clk);
    chk(htrans == 2'b00, "R7 end on incr_more low", htrans, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule